// File: doc/BRIEF.md
# Register-Programmed Packet Injector

This block lets software send an outgoing transaction-layer packet without a streaming master of its own. Software writes each 64-bit beat as two 32-bit halves on a small register bus. It then writes a control word whose two low bits mark start and end of packet. Each control write moves the staged pair and its flags into an internal beat FIFO. Once the end beat of a packet is in the FIFO, the packet is ready to go out.

A shared 64-bit output stream (data, start, end, valid, ready) is fed either from the FIFO or from a second streaming source. Ownership changes only between packets. At each packet boundary a ready register-built packet wins over the other source. The block also enforces the non-posted rules for the register path. Only one non-posted request may be pending at a time, and its tag must be between 16 and 31. An external pulse reports the completion that ends the pending request. The block sets sticky error flags for bad start/end sequences, for non-posted violations, and for control writes made while the FIFO is full.

Top module: `regPacketInjector`

## Requirements
- R1: A write to address 0 loads the low staging dword and a write to address 1 loads the high staging dword. A pushed beat appears on `outData` with the high dword in bits 63:32 and the low dword in bits 31:0.
- R2: A write to address 2 pushes the staged pair as one beat. Bit 0 of the written word is the start flag and bit 1 is the end flag, and they appear on `outSop`/`outEop`. The value 2'b11 forms a one-beat packet. The first output beat of every packet carries `outSop`.
- R3: The staging registers keep their contents across pushes. A beat pushed after only one half was rewritten carries the previous value in the other half.
- R4: A register-built packet is not offered on the output until its end beat has been pushed. While only part of a packet is staged and the other source is idle, `outValid` stays low.
- R5: At a packet boundary, a complete register-built packet is sent before a packet that the other source is already offering. `strmReady` stays low until the register packet has been fully sent.
- R6: Beats of the two sources never interleave. A packet from the other source that has started, including one with idle gaps between beats, finishes before a register packet begins.
- R7: A control write with start=0 while no packet is open, or start=1 while one is open, sets the sticky `errSequence` and is discarded. The open/closed state is unchanged.
- R8: The FIFO holds 8 beats. A control write while it is full sets the sticky `errOverflow` and is dropped, with no other effect.
- R9: A start beat is non-posted when its low dword has type field bits 28:24 equal to 0 or 1 with bit 30 clear (read), or type 2, 4 or 5 (I/O or configuration). Accepting such a beat sets `npPending`. A `cplRcvd` pulse clears it. If the pulse falls in the same cycle as a new non-posted start, the new request is legal and `npPending` stays set.
- R10: `errNonPosted` (sticky) is set when a non-posted start beat is accepted while a request is pending and no completion arrives that cycle. It is also set when the tag (bits 15:8 of the high dword) is outside 16..31. Posted starts never set it.
- R11: After reset, all flags, `npPending`, `outValid` and `strmReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 low dword, 1 high dword, 2 control |
| regWrData | input | 32 | Register write data |
| cplRcvd | input | 1 | One-cycle pulse: completion for the pending non-posted request |
| strmData | input | 64 | Other source beat data |
| strmSop | input | 1 | Other source start of packet |
| strmEop | input | 1 | Other source end of packet |
| strmValid | input | 1 | Other source beat valid |
| strmReady | output | 1 | Other source beat accepted |
| outData | output | 64 | Merged stream data |
| outSop | output | 1 | Merged stream start of packet |
| outEop | output | 1 | Merged stream end of packet |
| outValid | output | 1 | Merged stream beat valid |
| outReady | input | 1 | Downstream accepts the beat |
| npPending | output | 1 | A non-posted request is outstanding |
| errSequence | output | 1 | Sticky start/end ordering error |
| errNonPosted | output | 1 | Sticky non-posted rule error |
| errOverflow | output | 1 | Sticky FIFO-full write error |

## Verification
The critical overlap is a completion pulse arriving in the same cycle as the control write that starts a new non-posted request. The clear and the set of the pending bit then collide, and the rule check must see the old request as already finished. The bench drives `cplRcvd` high during exactly that control write. It expects `npPending` to stay set and `errNonPosted` to stay clear, and it also checks that a completion on its own clears the bit. A second overlap is a finished register packet while the other source is offering or mid-packet. The bench judges that case by the order of beats captured at the output.

// File: rtl/pktInjPkg.sv
package pktInjPkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic push;
    logic pushSop;
    logic pushEop;
  } injStrobe_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_STRM = 2'd2
  } srcSel_t;

  // Reads (no data), I/O and configuration requests expect a completion
  function automatic logic isNonPosted(input logic hasData, input logic [4:0] tlpType);
    logic np;
    case (tlpType)
      5'd0, 5'd1:       np = !hasData;
      5'd2, 5'd4, 5'd5: np = 1'b1;
      default:          np = 1'b0;
    endcase
    return np;
  endfunction

endpackage

// File: rtl/pktInjFifo.sv
module pktInjFifo #(
  parameter int unsigned WIDTH = 66,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [CNT_W-1:0] fill;
  logic doPush, doPop;

  assign full     = (fill == FULL_CNT);
  assign empty    = (fill == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = store[rdPtr];

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrNext = (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= wrNext;
      if (doPop)  rdPtr <= rdNext;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/pktInjArb.sv
module pktInjArb
  import pktInjPkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic [DATA_W-1:0] regData,
  input  logic              regSop,
  input  logic              regEop,
  output logic              regReady,
  input  logic              strmValid,
  input  logic [DATA_W-1:0] strmData,
  input  logic              strmSop,
  input  logic              strmEop,
  output logic              strmReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  input  logic              outReady
);
  srcSel_t lockOwner, curOwner;

  always_comb begin
    if (lockOwner != SRC_NONE)  curOwner = lockOwner;
    else if (regValid)          curOwner = SRC_REG;
    else if (strmValid)         curOwner = SRC_STRM;
    else                        curOwner = SRC_NONE;

    outValid = 1'b0;
    outData  = '0;
    outSop   = 1'b0;
    outEop   = 1'b0;
    case (curOwner)
      SRC_REG: begin
        outValid = regValid;
        outData  = regData;
        outSop   = regSop;
        outEop   = regEop;
      end
      SRC_STRM: begin
        outValid = strmValid;
        outData  = strmData;
        outSop   = strmSop;
        outEop   = strmEop;
      end
      default: ;
    endcase

    regReady  = outReady && (curOwner == SRC_REG);
    strmReady = outReady && (curOwner == SRC_STRM);
  end

  // Ownership is held from the first accepted beat to the last
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockOwner <= SRC_NONE;
    end else if (outValid && outReady) begin
      lockOwner <= outEop ? SRC_NONE : curOwner;
    end
  end
endmodule

// File: rtl/pktInjData.sv
module pktInjData
  import pktInjPkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  injStrobe_t        strobe,
  input  logic [DATA_W/2-1:0] regWrData,
  output logic              hdrHasData,
  output logic [4:0]        hdrType,
  output logic [TAG_W-1:0]  hdrTag,
  output logic              fifoFull,
  output logic              fifoPop,
  output logic              pktReady,
  input  logic              strmValid,
  input  logic [DATA_W-1:0] strmData,
  input  logic              strmSop,
  input  logic              strmEop,
  output logic              strmReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  input  logic              outReady
);
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned ENTRY_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);

  logic [HALF_W-1:0]  stageLow, stageHigh;
  logic [ENTRY_W-1:0] pushEntry, headEntry;
  logic               fifoEmpty, regReady, regValid;
  logic [CNT_W-1:0]   pktCount;
  logic               pktIn, pktOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageLow  <= '0;
      stageHigh <= '0;
    end else begin
      if (strobe.loadLow)  stageLow  <= regWrData;
      if (strobe.loadHigh) stageHigh <= regWrData;
    end
  end

  // Header fields for the non-posted check (valid on a start beat)
  assign hdrHasData = stageLow[30];
  assign hdrType    = stageLow[28:24];
  assign hdrTag     = stageHigh[15:8];

  assign pushEntry = {strobe.pushSop, strobe.pushEop, stageHigh, stageLow};

  pktInjFifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) fifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.push),
    .pushData (pushEntry),
    .pop      (fifoPop),
    .headData (headEntry),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  // Count of packets whose end beat is in the FIFO
  assign pktIn    = strobe.push && strobe.pushEop && !fifoFull;
  assign pktOut   = fifoPop && headEntry[DATA_W];
  assign pktReady = (pktCount != '0);
  assign regValid = !fifoEmpty && pktReady;
  assign fifoPop  = regValid && regReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktCount <= '0;
    end else begin
      case ({pktIn, pktOut})
        2'b10:   pktCount <= pktCount + 1'b1;
        2'b01:   pktCount <= pktCount - 1'b1;
        default: pktCount <= pktCount;
      endcase
    end
  end

  pktInjArb #(.DATA_W(DATA_W)) arb_i (
    .clk       (clk),
    .rstN      (rstN),
    .regValid  (regValid),
    .regData   (headEntry[DATA_W-1:0]),
    .regSop    (headEntry[DATA_W+1]),
    .regEop    (headEntry[DATA_W]),
    .regReady  (regReady),
    .strmValid (strmValid),
    .strmData  (strmData),
    .strmSop   (strmSop),
    .strmEop   (strmEop),
    .strmReady (strmReady),
    .outValid  (outValid),
    .outData   (outData),
    .outSop    (outSop),
    .outEop    (outEop),
    .outReady  (outReady)
  );
endmodule

// File: rtl/pktInjCtrl.sv
module pktInjCtrl
  import pktInjPkg::*;
#(
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned TAG_LO = 16,
  parameter int unsigned TAG_HI = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        ctrlBits,
  input  logic              hdrHasData,
  input  logic [4:0]        hdrType,
  input  logic [TAG_W-1:0]  hdrTag,
  input  logic              fifoFull,
  input  logic              cplRcvd,
  output injStrobe_t        strobe,
  output logic              npAccept,
  output logic              npPending,
  output logic              errSequence,
  output logic              errNonPosted,
  output logic              errOverflow
);
  localparam logic [TAG_W-1:0] TAG_MIN = TAG_W'(TAG_LO);
  localparam logic [TAG_W-1:0] TAG_MAX = TAG_W'(TAG_HI);

  logic ctrlWr, pktOpen, seqBad, tagBad, npClash;

  always_comb begin
    ctrlWr          = regWrEn && (regAddr == ADDR_CTRL);
    seqBad          = (ctrlBits[0] == pktOpen);
    strobe.loadLow  = regWrEn && (regAddr == ADDR_LOW);
    strobe.loadHigh = regWrEn && (regAddr == ADDR_HIGH);
    strobe.push     = ctrlWr && !fifoFull && !seqBad;
    strobe.pushSop  = ctrlBits[0];
    strobe.pushEop  = ctrlBits[1];
    tagBad          = (hdrTag < TAG_MIN) || (hdrTag > TAG_MAX);
    npAccept        = strobe.push && ctrlBits[0] && isNonPosted(hdrHasData, hdrType);
    npClash         = npPending && !cplRcvd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktOpen      <= 1'b0;
      npPending    <= 1'b0;
      errSequence  <= 1'b0;
      errNonPosted <= 1'b0;
      errOverflow  <= 1'b0;
    end else begin
      if (strobe.push)                        pktOpen     <= !ctrlBits[1];
      if (ctrlWr && fifoFull)                 errOverflow <= 1'b1;
      if (ctrlWr && !fifoFull && seqBad)      errSequence <= 1'b1;
      if (npAccept)                           npPending   <= 1'b1;
      else if (cplRcvd)                       npPending   <= 1'b0;
      if (npAccept && (npClash || tagBad))    errNonPosted <= 1'b1;
    end
  end
endmodule

// File: rtl/regPacketInjector.sv
module regPacketInjector
  import pktInjPkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned TAG_LO     = 16,
  parameter int unsigned TAG_HI     = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W/2-1:0] regWrData,
  input  logic              cplRcvd,
  input  logic [DATA_W-1:0] strmData,
  input  logic              strmSop,
  input  logic              strmEop,
  input  logic              strmValid,
  output logic              strmReady,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  output logic              outValid,
  input  logic              outReady,
  output logic              npPending,
  output logic              errSequence,
  output logic              errNonPosted,
  output logic              errOverflow
);
  localparam int unsigned TAG_W = 8;

  injStrobe_t       strobe;
  logic             hdrHasData;
  logic [4:0]       hdrType;
  logic [TAG_W-1:0] hdrTag;
  logic             fifoFull, fifoPop, pktReady, npAccept;

  pktInjCtrl #(.TAG_W(TAG_W), .TAG_LO(TAG_LO), .TAG_HI(TAG_HI)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .ctrlBits     (regWrData[1:0]),
    .hdrHasData   (hdrHasData),
    .hdrType      (hdrType),
    .hdrTag       (hdrTag),
    .fifoFull     (fifoFull),
    .cplRcvd      (cplRcvd),
    .strobe       (strobe),
    .npAccept     (npAccept),
    .npPending    (npPending),
    .errSequence  (errSequence),
    .errNonPosted (errNonPosted),
    .errOverflow  (errOverflow)
  );

  pktInjData #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .TAG_W(TAG_W)) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWrData  (regWrData),
    .hdrHasData (hdrHasData),
    .hdrType    (hdrType),
    .hdrTag     (hdrTag),
    .fifoFull   (fifoFull),
    .fifoPop    (fifoPop),
    .pktReady   (pktReady),
    .strmValid  (strmValid),
    .strmData   (strmData),
    .strmSop    (strmSop),
    .strmEop    (strmEop),
    .strmReady  (strmReady),
    .outValid   (outValid),
    .outData    (outData),
    .outSop     (outSop),
    .outEop     (outEop),
    .outReady   (outReady)
  );
endmodule

// File: rtl/pktInjChecker.sv
module pktInjChecker (
  input logic clk,
  input logic rstN,
  input logic pushStb,
  input logic fifoFull,
  input logic fifoPop,
  input logic pktReady,
  input logic npAccept,
  input logic npPending,
  input logic cplRcvd,
  input logic errSequence,
  input logic errNonPosted,
  input logic errOverflow,
  input logic outValid,
  input logic outReady,
  input logic outSop,
  input logic outEop,
  input logic strmValid,
  input logic strmReady
);
  // Packet-boundary tracking seen from the output port
  logic inPkt, lastReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPkt   <= 1'b0;
      lastReg <= 1'b0;
    end else if (outValid && outReady) begin
      inPkt   <= !outEop;
      lastReg <= fifoPop;
    end
  end

  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    pushStb |-> !fifoFull);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |=> errOverflow);
  a_r7_seq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errSequence |=> errSequence);
  a_r10_np_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errNonPosted |=> errNonPosted);
  a_r9_accept_sets: assert property (@(posedge clk) disable iff (!rstN)
    npAccept |=> npPending);
  a_r9_cpl_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cplRcvd && !npAccept) |=> !npPending);
  a_r5_reg_first: assert property (@(posedge clk) disable iff (!rstN)
    (!inPkt && pktReady) |-> !strmReady);
  a_r6_one_source: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoPop && strmValid && strmReady));
  a_r6_hold_reg: assert property (@(posedge clk) disable iff (!rstN)
    (inPkt && lastReg) |-> !(strmValid && strmReady));
  a_r6_hold_strm: assert property (@(posedge clk) disable iff (!rstN)
    (inPkt && !lastReg) |-> !fifoPop);
  a_r2_first_sop: assert property (@(posedge clk) disable iff (!rstN)
    (!inPkt && outValid) |-> outSop);
endmodule

bind regPacketInjector pktInjChecker chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .pushStb      (strobe.push),
  .fifoFull     (fifoFull),
  .fifoPop      (fifoPop),
  .pktReady     (pktReady),
  .npAccept     (npAccept),
  .npPending    (npPending),
  .cplRcvd      (cplRcvd),
  .errSequence  (errSequence),
  .errNonPosted (errNonPosted),
  .errOverflow  (errOverflow),
  .outValid     (outValid),
  .outReady     (outReady),
  .outSop       (outSop),
  .outEop       (outEop),
  .strmValid    (strmValid),
  .strmReady    (strmReady)
);

// File: tb/regPacketInjector_tb_top.sv
module regPacketInjector_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        cplRcvd = 1'b0;
  logic [63:0] strmData = '0;
  logic        strmSop = 1'b0, strmEop = 1'b0, strmValid = 1'b0;
  logic        strmReady;
  logic [63:0] outData;
  logic        outSop, outEop, outValid;
  logic        outReady = 1'b1;
  logic        npPending, errSequence, errNonPosted, errOverflow;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [63:0] logData [64];
  logic        logSop  [64];
  logic        logEop  [64];
  int          logN = 0;

  always #4 clk = ~clk;

  regPacketInjector dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .cplRcvd(cplRcvd), .strmData(strmData), .strmSop(strmSop), .strmEop(strmEop),
    .strmValid(strmValid), .strmReady(strmReady), .outData(outData), .outSop(outSop),
    .outEop(outEop), .outValid(outValid), .outReady(outReady), .npPending(npPending),
    .errSequence(errSequence), .errNonPosted(errNonPosted), .errOverflow(errOverflow)
  );

  // Output beat log: values seen just before the accepting edge
  always @(posedge clk) begin
    if (rstN && outValid && outReady && logN < 64) begin
      logData[logN] = outData;
      logSop[logN]  = outSop;
      logEop[logN]  = outEop;
      logN = logN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkBeat(input string req, input int idx, input logic [63:0] d,
                           input logic s, input logic e);
    check(logData[idx] === d, req, $sformatf("beat %0d data", idx), logData[idx], d);
    check({logSop[idx], logEop[idx]} === {s, e}, req, $sformatf("beat %0d sop/eop", idx),
          {62'd0, logSop[idx], logEop[idx]}, {62'd0, s, e});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 1'b0; cplRcvd = 1'b0; strmValid = 1'b0; outReady = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    logN = 0;
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d, input bit cpl);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; cplRcvd = cpl;
    @(negedge clk);
    regWrEn = 1'b0; cplRcvd = 1'b0;
  endtask

  task automatic beat(input logic [31:0] lo, input logic [31:0] hi, input logic [1:0] c);
    regWrite(2'd0, lo, 1'b0);
    regWrite(2'd1, hi, 1'b0);
    regWrite(2'd2, {30'd0, c}, 1'b0);
  endtask

  task automatic beatCpl(input logic [31:0] lo, input logic [31:0] hi, input logic [1:0] c);
    regWrite(2'd0, lo, 1'b0);
    regWrite(2'd1, hi, 1'b0);
    regWrite(2'd2, {30'd0, c}, 1'b1);
  endtask

  task automatic streamSend(input int n, input logic [63:0] base, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      strmValid = 1'b1; strmData = base + 64'(i);
      strmSop = (i == 0); strmEop = (i == n - 1);
      #1;
      while (!strmReady) begin @(negedge clk); #1; end
      @(posedge clk);
      if (gap > 0) begin
        @(negedge clk); strmValid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    strmValid = 1'b0; strmSop = 1'b0; strmEop = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(outValid === 1'b0, "R11", "outValid", {63'd0, outValid}, 64'd0);
    check(strmReady === 1'b0, "R11", "strmReady", {63'd0, strmReady}, 64'd0);
    check({npPending, errSequence, errNonPosted, errOverflow} === 4'd0, "R11", "flags",
          {60'd0, npPending, errSequence, errNonPosted, errOverflow}, 64'd0);
  endtask

  task automatic testBasic();
    doReset();
    beat(32'h4000_0002, 32'h0000_0A0F, 2'b01);
    check(outValid === 1'b0, "R4", "after start beat", {63'd0, outValid}, 64'd0);
    beat(32'h1111_1111, 32'h2222_2222, 2'b00);
    check(outValid === 1'b0, "R4", "after middle beat", {63'd0, outValid}, 64'd0);
    regWrite(2'd0, 32'h3333_3333, 1'b0);
    regWrite(2'd2, 32'd2, 1'b0);
    check(outValid === 1'b1, "R4", "after end beat", {63'd0, outValid}, 64'd1);
    repeat (6) @(negedge clk);
    check(logN == 3, "R2", "beat count", 64'(logN), 64'd3);
    checkBeat("R1", 0, 64'h0000_0A0F_4000_0002, 1'b1, 1'b0);
    checkBeat("R2", 1, 64'h2222_2222_1111_1111, 1'b0, 1'b0);
    checkBeat("R3", 2, 64'h2222_2222_3333_3333, 1'b0, 1'b1);
    logN = 0;
    beat(32'h5555_0001, 32'h6666_0002, 2'b11);
    repeat (4) @(negedge clk);
    check(logN == 1, "R2", "single-beat count", 64'(logN), 64'd1);
    checkBeat("R2", 0, 64'h6666_0002_5555_0001, 1'b1, 1'b1);
  endtask

  task automatic testPriority();
    doReset();
    outReady = 1'b0;
    fork
      streamSend(2, 64'hABCD_0000_0000_0010, 0);
      begin
        beat(32'hA000_0001, 32'hA000_0002, 2'b01);
        beat(32'hB000_0001, 32'hB000_0002, 2'b10);
        #2;
        check(strmReady === 1'b0, "R5", "stream held", {63'd0, strmReady}, 64'd0);
        outReady = 1'b1;
      end
    join
    repeat (4) @(negedge clk);
    check(logN == 4, "R5", "beat count", 64'(logN), 64'd4);
    checkBeat("R5", 0, 64'hA000_0002_A000_0001, 1'b1, 1'b0);
    checkBeat("R5", 1, 64'hB000_0002_B000_0001, 1'b0, 1'b1);
    checkBeat("R5", 2, 64'hABCD_0000_0000_0010, 1'b1, 1'b0);
    checkBeat("R5", 3, 64'hABCD_0000_0000_0011, 1'b0, 1'b1);
  endtask

  task automatic testNoInterleave();
    doReset();
    fork
      streamSend(6, 64'h5700_0000_0000_0000, 2);
      begin
        repeat (2) @(negedge clk);
        beat(32'hC000_0001, 32'hC000_0002, 2'b11);
      end
    join
    repeat (4) @(negedge clk);
    check(logN == 7, "R6", "beat count", 64'(logN), 64'd7);
    for (int i = 0; i < 6; i++)
      checkBeat("R6", i, 64'h5700_0000_0000_0000 + 64'(i), i == 0, i == 5);
    checkBeat("R6", 6, 64'hC000_0002_C000_0001, 1'b1, 1'b1);
  endtask

  task automatic testSequence();
    doReset();
    regWrite(2'd2, 32'd0, 1'b0);
    repeat (3) @(negedge clk);
    check(errSequence === 1'b1, "R7", "middle with no open packet", {63'd0, errSequence}, 64'd1);
    check(logN == 0, "R7", "nothing sent", 64'(logN), 64'd0);
    doReset();
    beat(32'hD000_0001, 32'hD000_0002, 2'b01);
    beat(32'hE000_0001, 32'hE000_0002, 2'b01);
    check(errSequence === 1'b1, "R7", "start while open", {63'd0, errSequence}, 64'd1);
    beat(32'hF000_0001, 32'hF000_0002, 2'b10);
    repeat (4) @(negedge clk);
    check(logN == 2, "R7", "discarded beat absent", 64'(logN), 64'd2);
    checkBeat("R7", 0, 64'hD000_0002_D000_0001, 1'b1, 1'b0);
    checkBeat("R7", 1, 64'hF000_0002_F000_0001, 1'b0, 1'b1);
  endtask

  task automatic testOverflow();
    doReset();
    outReady = 1'b0;
    beat(32'h0, 32'h0, 2'b01);
    for (int i = 0; i < 7; i++) beat(32'(i), 32'(i), 2'b00);
    check(errOverflow === 1'b0, "R8", "eight beats fit", {63'd0, errOverflow}, 64'd0);
    regWrite(2'd2, 32'd2, 1'b0);
    check(errOverflow === 1'b1, "R8", "write when full", {63'd0, errOverflow}, 64'd1);
    check(errSequence === 1'b0, "R8", "no sequence error", {63'd0, errSequence}, 64'd0);
    outReady = 1'b1;
    repeat (4) @(negedge clk);
    check(outValid === 1'b0 && logN == 0, "R8", "dropped end beat not pushed",
          64'(logN), 64'd0);
  endtask

  task automatic testNonPosted();
    doReset();
    beat(32'h0000_0001, 32'h0000_1000, 2'b01);   // read, tag 16
    check(npPending === 1'b1, "R9", "pending after read", {63'd0, npPending}, 64'd1);
    beat(32'h0000_0040, 32'h0, 2'b10);
    beat(32'h4000_0001, 32'h0000_0500, 2'b11);   // posted write, tag 5
    check(errNonPosted === 1'b0, "R10", "posted ignored", {63'd0, errNonPosted}, 64'd0);
    beat(32'h0000_0001, 32'h0000_1400, 2'b11);   // second read, tag 20
    check(errNonPosted === 1'b1, "R10", "second non-posted", {63'd0, errNonPosted}, 64'd1);

    doReset();
    beat(32'h0000_0001, 32'h0000_0500, 2'b11);   // tag 5
    check(errNonPosted === 1'b1, "R10", "tag 5", {63'd0, errNonPosted}, 64'd1);
    doReset();
    beat(32'h0000_0001, 32'h0000_2000, 2'b11);   // tag 32
    check(errNonPosted === 1'b1, "R10", "tag 32", {63'd0, errNonPosted}, 64'd1);

    doReset();
    beat(32'h4400_0001, 32'h0000_1200, 2'b11);   // config write, tag 18
    check(npPending === 1'b1, "R9", "config write non-posted", {63'd0, npPending}, 64'd1);
    @(negedge clk); cplRcvd = 1'b1;
    @(negedge clk); cplRcvd = 1'b0;
    check(npPending === 1'b0, "R9", "completion clears", {63'd0, npPending}, 64'd0);
    beat(32'h0000_0001, 32'h0000_1F00, 2'b11);   // tag 31
    beatCpl(32'h0000_0001, 32'h0000_1100, 2'b11); // tag 17 with completion same cycle
    check(npPending === 1'b1, "R9", "same-cycle completion keeps new", {63'd0, npPending}, 64'd1);
    check(errNonPosted === 1'b0, "R9", "same-cycle completion legal",
          {63'd0, errNonPosted}, 64'd0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    testReset();
    testBasic();
    testPriority();
    testNoInterleave();
    testSequence();
    testOverflow();
    testNonPosted();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end
endmodule